// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Nine-bit words are written on the write clock and read into an output register on the read clock. Four active-low status outputs report the fill state: empty, full, almost-empty and almost-full. The empty pair is produced in the read domain and the full pair in the write domain. Each domain compares its own pointer with a Gray-coded copy of the other domain's pointer that has passed through a two-flop synchronizer.

The write port has two enables. The second write enable is a dual-role pin, and its level while reset is held low selects its role. High selects the second-write-enable role (state `ROLE_DUAL_EN`): the pin only gates writes, and both thresholds stay at the default of 7. Low selects the load-control role (state `ROLE_LOAD_CTRL`): the pin, when low, hands both ports to an external offset-register block, and the thresholds come from the `ae_offset` and `af_offset` inputs that this block supplies. The role state changes only through the transition taken on a clock edge while reset is low. The data outputs can be put into high impedance with an output enable.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wr_en1_n` is 0, `wr_en2_ld` is 1 and `full_n` is 1. With `wr_en2_ld` at 0 no word is stored.
- R2: A word is read into the output register on a rising `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. In the load-control role `wr_en2_ld` must also be 1.
- R3: `wr_en2_ld` sampled while `rst_n` is 0 selects the role: 1 gives `ROLE_DUAL_EN`, 0 gives `ROLE_LOAD_CTRL`. In `ROLE_DUAL_EN` the pin has no effect on reads, and both thresholds are 7 whatever the offset inputs hold. In `ROLE_LOAD_CTRL` the thresholds are n = `ae_offset` and m = `af_offset`.
- R4: Words leave the FIFO in the order in which they were written, and each value is unchanged.
- R5: `empty_n` is 0 exactly when no unread word remains. `full_n` is 0 exactly when DEPTH words are held. Both settle after the pointer synchronizers have passed on the change.
- R6: `almost_empty_n` is 0 when n or fewer unread words remain and 1 at n+1 or more. It is updated only by `rd_clk`.
- R7: `almost_full_n` is 0 when the word count is DEPTH−m or more and 1 otherwise. It is updated only by `wr_clk`.
- R8: After reset `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1, and the output register holds 0.
- R9: Writes attempted while full are dropped, and the stored words are not disturbed.
- R10: Reads attempted while empty leave `rd_data` at the last word read.
- R11: With `out_en_n`=1, `rd_data` is high impedance. With `out_en_n`=0, it drives the output register.
- R12: The first written word reaches `rd_data` on the read edge after `empty_n` has gone high. Until then the output register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_data | input | 9 | Write data |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Dual-role pin: second write enable or offset load control |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| out_en_n | input | 1 | Output enable, active low; 1 gives high impedance |
| ae_offset | input | 5 | Almost-empty offset n from the offset-register block |
| af_offset | input | 5 | Almost-full offset m from the offset-register block |
| rd_data | output | 9 | Read data (output register) |
| empty_n | output | 1 | 0 when empty |
| almost_empty_n | output | 1 | 0 when n or fewer words remain |
| almost_full_n | output | 1 | 0 when DEPTH−m or more words are held |
| full_n | output | 1 | 0 when full |

## Verification
The bench fills and drains the FIFO completely for four threshold settings. These include n and m of 0, and a dual-enable setting whose offset inputs hold values that must be ignored. A threshold off by one would move the almost-empty or almost-full edge by a single word and fail a flag check at that fill level. Extra writes at full and extra reads at empty catch a design that overwrites the oldest word or shifts stale data out. Directed cases cover the role pin: a design that ignores its level during reset would pass or block the wrong reads. A design that skips the output register would show the first word before the read edge.

// File: rtl/fifo_cfg_pkg.sv
package fifo_cfg_pkg;

    // Role of the dual-purpose write enable, fixed while reset is low.
    typedef enum logic {
        ROLE_DUAL_EN   = 1'b0,
        ROLE_LOAD_CTRL = 1'b1
    } role_e;

    // Threshold used for both almost flags when no offsets are loaded.
    localparam int DEFAULT_OFS = 7;

endpackage

// File: rtl/fifo_role_fsm.sv
module fifo_role_fsm
    import fifo_cfg_pkg::*;
#(
    parameter int OFS_W     = 5,
    parameter bit READ_SIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_pin,
    input  logic [OFS_W-1:0] ofs_in,
    output logic             fifo_gate,
    output logic [OFS_W-1:0] ofs_eff
);

    role_e role_q, role_d;

    // Next state: the role is latched only while reset is held low.
    always_comb begin
        role_d = role_q;
        if (!rst_n) begin
            role_d = dual_pin ? ROLE_DUAL_EN : ROLE_LOAD_CTRL;
        end
    end

    always_ff @(posedge clk) begin
        role_q <= role_d;
    end

    // Outputs per role.
    always_comb begin
        unique case (role_q)
            ROLE_DUAL_EN: begin
                fifo_gate = READ_SIDE ? 1'b1 : dual_pin;
                ofs_eff   = OFS_W'(DEFAULT_OFS);
            end
            ROLE_LOAD_CTRL: begin
                fifo_gate = dual_pin;
                ofs_eff   = ofs_in;
            end
            default: begin
                fifo_gate = 1'b0;
                ofs_eff   = '0;
            end
        endcase
    end

endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [1 << ADDR_W];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
    parameter  int ADDR_W = 4,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [PTR_W-1:0] rgray_sync,
    input  logic [PTR_W-1:0] m_ofs,
    output logic [PTR_W-1:0] wbin,
    output logic [PTR_W-1:0] wgray,
    output logic             wr_fire,
    output logic             full_n,
    output logic             afull_n
);

    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [PTR_W-1:0] rbin_s, wnext, cnt_nx;
    logic [PTR_W:0]   af_limit;

    assign wr_fire  = wr_req && full_n;
    assign rbin_s   = g2b(rgray_sync);
    assign wnext    = wbin + PTR_W'(wr_fire);
    assign cnt_nx   = wnext - rbin_s;
    assign af_limit = (PTR_W+1)'(DEPTH) - {1'b0, m_ofs};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wnext;
            wgray   <= wnext ^ (wnext >> 1);
            full_n  <= (cnt_nx != PTR_W'(DEPTH));
            afull_n <= ({1'b0, cnt_nx} < af_limit);
        end
    end

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
    parameter  int DATA_W = 9,
    parameter  int ADDR_W = 4,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [PTR_W-1:0]  n_ofs,
    input  logic [DATA_W-1:0] ram_q,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output logic [DATA_W-1:0] out_q,
    output logic              empty_n,
    output logic              aempty_n
);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic             rd_fire;
    logic [PTR_W-1:0] wbin_s, rnext, cnt_nx;

    assign rd_fire = rd_req && empty_n;
    assign wbin_s  = g2b(wgray_sync);
    assign rnext   = rbin + PTR_W'(rd_fire);
    assign cnt_nx  = wbin_s - rnext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            out_q    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rnext;
            rgray    <= rnext ^ (rnext >> 1);
            empty_n  <= (cnt_nx != '0);
            aempty_n <= (cnt_nx > n_ofs);
            if (rd_fire) begin
                out_q <= ram_q;
            end
        end
    end

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter  int DATA_W = 9,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              out_en_n,
    input  logic [PTR_W-1:0]  ae_offset,
    input  logic [PTR_W-1:0]  af_offset,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic              almost_full_n,
    output logic              full_n
);

    logic             wr_gate, rd_gate, wr_fire;
    logic [PTR_W-1:0] m_eff, n_eff;
    logic [PTR_W-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PTR_W-1:0] wr_gray_rs, rd_gray_ws;
    logic [DATA_W-1:0] ram_q, rd_q;

    fifo_role_fsm #(.OFS_W(PTR_W), .READ_SIDE(1'b0)) wr_role_i (
        .clk(wr_clk), .rst_n(rst_n), .dual_pin(wr_en2_ld),
        .ofs_in(af_offset), .fifo_gate(wr_gate), .ofs_eff(m_eff)
    );

    fifo_role_fsm #(.OFS_W(PTR_W), .READ_SIDE(1'b1)) rd_role_i (
        .clk(rd_clk), .rst_n(rst_n), .dual_pin(wr_en2_ld),
        .ofs_in(ae_offset), .fifo_gate(rd_gate), .ofs_eff(n_eff)
    );

    fifo_wr_ctl #(.ADDR_W(ADDR_W)) wr_ctl_i (
        .clk(wr_clk), .rst_n(rst_n),
        .wr_req(!wr_en1_n && wr_gate),
        .rgray_sync(rd_gray_ws), .m_ofs(m_eff),
        .wbin(wr_bin), .wgray(wr_gray), .wr_fire(wr_fire),
        .full_n(full_n), .afull_n(almost_full_n)
    );

    fifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_ctl_i (
        .clk(rd_clk), .rst_n(rst_n),
        .rd_req(!rd_en1_n && !rd_en2_n && rd_gate),
        .wgray_sync(wr_gray_rs), .n_ofs(n_eff), .ram_q(ram_q),
        .rbin(rd_bin), .rgray(rd_gray), .out_q(rd_q),
        .empty_n(empty_n), .aempty_n(almost_empty_n)
    );

    fifo_gray_sync #(.W(PTR_W)) w2r_sync_i (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_rs)
    );

    fifo_gray_sync #(.W(PTR_W)) r2w_sync_i (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_ws)
    );

    fifo_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .wr_clk(wr_clk), .we(wr_fire),
        .waddr(wr_bin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rd_bin[ADDR_W-1:0]), .rdata(ram_q)
    );

    assign rd_data = out_en_n ? 'z : rd_q;

endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk #(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 5
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              full_n,
    input logic              afull_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic              out_en_n,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  rptr,
    input logic [DATA_W-1:0] q,
    input logic [DATA_W-1:0] dout
);

    // R9
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wptr));

    // R10
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> ($stable(rptr) && $stable(q)));

    // R6
    empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R7
    full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R11
    out_drive_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !out_en_n |-> (dout == q));

endmodule

bind dcfifo_pflag fifo_flag_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) flag_chk_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .full_n(full_n), .afull_n(almost_full_n),
    .empty_n(empty_n), .aempty_n(almost_empty_n),
    .out_en_n(out_en_n), .wptr(wr_bin), .rptr(rd_bin),
    .q(rd_q), .dout(rd_data)
);

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb_top;

    localparam int DEPTH = 16;
    localparam int PW    = 5;

    // Threshold table: load_role, ae_offset, af_offset, expected n, expected m
    localparam int CFG [4][5] = '{
        '{0, 3, 2, 7, 7},
        '{1, 3, 2, 3, 2},
        '{1, 0, 0, 0, 0},
        '{1, 12, 5, 12, 5}
    };

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    wr_data = '0;
    logic          wr_en1_n = 1'b1;
    logic          wr_en2_ld = 1'b1;
    logic          rd_en1_n = 1'b1;
    logic          rd_en2_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic [PW-1:0] ae_offset = '0;
    logic [PW-1:0] af_offset = '0;
    wire  [8:0]    rd_data;
    logic          empty_n, almost_empty_n, almost_full_n, full_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic [8:0] last_word;

    always #10 wr_clk = ~wr_clk;
    always #17 rd_clk = ~rd_clk;

    dcfifo_pflag #(.DATA_W(9), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
        .ae_offset(ae_offset), .af_offset(af_offset),
        .rd_data(rd_data), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
        .full_n(full_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
    endtask

    task automatic do_reset(input bit load_role);
        rst_n     = 1'b0;
        wr_en1_n  = 1'b1;
        rd_en1_n  = 1'b1;
        rd_en2_n  = 1'b1;
        wr_en2_ld = !load_role;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n     = 1'b1;
        wr_en2_ld = 1'b1;
        settle();
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wr_clk);
        wr_data  = d;
        wr_en1_n = 1'b0;
        @(negedge wr_clk);
        wr_en1_n = 1'b1;
    endtask

    task automatic pop2(input logic e1, input logic e2);
        @(negedge rd_clk);
        rd_en1_n = e1;
        rd_en2_n = e2;
        @(negedge rd_clk);
        rd_en1_n = 1'b1;
        rd_en2_n = 1'b1;
    endtask

    task automatic chk_flags(input int cnt, input int n, input int m);
        chk("R5 empty_n", int'(empty_n), int'(cnt != 0));
        chk("R5 full_n", int'(full_n), int'(cnt != DEPTH));
        chk("R6 almost_empty_n", int'(almost_empty_n), int'(cnt > n));
        chk("R7 almost_full_n", int'(almost_full_n), int'(cnt < DEPTH - m));
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        do_reset(1'b0);
        chk("R8 rd_data", int'(rd_data), 0);
        chk_flags(0, 7, 7);

        // R11: output enable high gives high impedance
        out_en_n = 1'b1;
        #1;
        chk("R11 high-z", int'(rd_data === 9'bzzzzzzzzz), 1);
        out_en_n = 1'b0;
        #1;
        chk("R11 driven", int'(rd_data), 0);

        // Vector table: fill, overflow, drain, underflow per threshold set
        for (int v = 0; v < 4; v++) begin
            ae_offset = PW'(CFG[v][1]);
            af_offset = PW'(CFG[v][2]);
            do_reset(CFG[v][0] != 0);
            for (int i = 0; i < DEPTH; i++) begin
                push(9'(v * 40 + i + 1));
                settle();
                chk_flags(i + 1, CFG[v][3], CFG[v][4]);
            end
            // R9: extra writes while full are dropped
            push(9'h1AA);
            push(9'h155);
            settle();
            chk("R9 full_n after overflow", int'(full_n), 0);
            for (int i = 0; i < DEPTH; i++) begin
                pop2(1'b0, 1'b0);
                chk("R4 order", int'(rd_data), v * 40 + i + 1);
                settle();
                chk_flags(DEPTH - 1 - i, CFG[v][3], CFG[v][4]);
            end
            // R10: read while empty keeps last word
            pop2(1'b0, 1'b0);
            settle();
            chk("R10 hold last", int'(rd_data), v * 40 + DEPTH);
        end

        // R12: first word appears only after the read edge following empty_n high
        do_reset(1'b0);
        push(9'h0A5);
        for (int k = 0; k < 20 && !empty_n; k++) @(negedge rd_clk);
        chk("R12 empty_n rose", int'(empty_n), 1);
        chk("R12 no early data", int'(rd_data), 0);
        pop2(1'b0, 1'b0);
        chk("R12 first word", int'(rd_data), 'h0A5);

        // R1: second write enable low blocks writes in dual-enable role
        do_reset(1'b0);
        wr_en2_ld = 1'b0;
        push(9'h011);
        settle();
        wr_en2_ld = 1'b1;
        chk("R1 write blocked", int'(empty_n), 0);

        // R2: a single read enable is not enough
        push(9'h0C3);
        settle();
        pop2(1'b0, 1'b1);
        chk("R2 one enable", int'(rd_data), 0);
        pop2(1'b1, 1'b0);
        chk("R2 other enable", int'(rd_data), 0);

        // R3: dual-enable role, pin low does not block reads
        wr_en2_ld = 1'b0;
        pop2(1'b0, 1'b0);
        wr_en2_ld = 1'b1;
        chk("R3 dual role read", int'(rd_data), 'h0C3);

        // R2/R3: load-control role, pin low diverts reads away from the FIFO
        do_reset(1'b1);
        push(9'h022);
        push(9'h033);
        settle();
        wr_en2_ld = 1'b0;
        pop2(1'b0, 1'b0);
        chk("R2 load role read blocked", int'(rd_data), 0);
        wr_en2_ld = 1'b1;
        pop2(1'b0, 1'b0);
        chk("R3 load role read", int'(rd_data), 'h022);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule